// File: doc/BRIEF.md
# Chained-Command Block Transfer Channel

This block is a peripheral transfer channel that moves characters between word-organised memory and one of several devices without processor help. It is started with the word address of a device command. It steals memory cycles to fetch that command, checks the command's odd parity and type marker, and decodes the target device, the device operation and whether data moves at all. A command that moves no data ends the channel's work at once.

For a data command the channel reads a run of block-control words that follow the command in memory. Each of these words gives a character address, a character count and a continue flag. The channel then moves one 8-bit character per device demand, stepping the address and the count each time. Four characters share a memory word. Each word is read once before its characters are used. On input, the word is written back after its last lane is filled or when the block ends, so lanes outside the block keep their contents.

When a block runs out, the continue flag selects between fetching the next block-control word and finishing. Finishing raises a one-cycle interrupt. A malformed control word or a parity failure sets an error flag and also finishes with the interrupt.

Top module: `xfer_chan`

## Requirements
- R1: A start pulse while idle loads the start address into the command pointer. From the next cycle the channel is busy and requests a memory read at that address.
- R2: Every fetched word is checked for odd parity over its 32 data bits and parity bit. A failure sets `err`, pulses `irq` and returns the channel to idle.
- R3: A command word must have data bit 31 = 1. Otherwise `err` is set and `irq` pulses. In a command, bit 30 set means data moves, bits 29:26 are the device number and bits 25:16 are the device operation. Operation bit 25 set means output (memory to device).
- R4: A valid command with bit 30 = 0 returns the channel to idle. It moves no character, raises no `irq` and leaves `err` clear.
- R5: A block-control word must have bit 31 = 0, or `err` is set and `irq` pulses. In this word, bit 30 is the continue flag, bits 23:16 are the character count and bits 15:0 are the character address (word address in bits 15:2, lane in bits 1:0). A block with count 0 moves nothing.
- R6: On output, the character at character address a is bits 8*(a mod 4)+7 to 8*(a mod 4) of word a/4. One such character is handed out per acknowledged demand, in ascending address order across word boundaries. The channel never writes memory during an output.
- R7: On input, accepted characters are stored in ascending character addresses. Lanes of a touched word that lie outside the block keep their old value, and every written word carries odd parity.
- R8: When a block's count is used up, a set continue flag fetches the next block-control word from the following command-pointer address. A clear flag ends the transfer: `irq` is high for exactly one cycle and `busy` is low from that cycle on.
- R9: A start pulse while busy is ignored. The running transfer is unaffected and `start_ignored` is high for one cycle.
- R10: A memory request that is not granted is held, with its address and write flag unchanged, until granted.
- R11: `dev_ack` is given only in answer to `dev_req` while a transfer is moving characters. `dev_sel`, `dev_op` and `dev_out` show the decoded command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request |
| start_addr | input | AW | Word address of the device command |
| busy | output | 1 | Channel is working |
| start_ignored | output | 1 | One-cycle pulse: start arrived while busy |
| irq | output | 1 | One-cycle completion interrupt |
| err | output | 1 | Error flag of the last transfer |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_wpar | output | 1 | Odd parity of write data |
| mem_gnt | input | 1 | Cycle granted; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| mem_rpar | input | 1 | Read parity bit |
| dev_sel | output | DEVW | Selected device |
| dev_op | output | OPW | Device operation |
| dev_out | output | 1 | Direction: 1 = memory to device |
| dev_active | output | 1 | Data command in progress |
| dev_req | input | 1 | Device demands a character |
| dev_ack | output | 1 | Character handed out or taken this cycle |
| dev_wdata | output | 8 | Output character |
| dev_rdata | input | 8 | Input character |

## Verification
The hardest case to reach is an input block that begins and ends in the middle of a word while other requesters hold off the memory grant. In that case the read-modify-write must keep foreign lanes intact, even though each character arrives only after a stalled refetch. The bench sweeps grant delays of zero to two cycles against device demand spacings of one to three cycles. For each pair it runs a chained output transfer that crosses word boundaries and includes an empty block, followed by an unaligned chained input transfer. It then compares memory word by word, including parity, with a model built before the transfer.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_FCMD,
      S_FBLK,
      S_FDATA,
      S_MOVE,
      S_WBACK
   } xfer_state_t;

   localparam int MARK_BIT  = 31;
   localparam int FLAG_BIT  = 30;
   localparam int FIELD_LSB = 16;
endpackage

// File: rtl/xfer_parity.sv
module xfer_parity #(
   parameter int DW  = 32,
   parameter bit ODD = 1'b1
) (
   input  logic [DW-1:0] rd_data,
   input  logic          rd_par,
   output logic          rd_ok,
   input  logic [DW-1:0] wr_data,
   output logic          wr_par
);
   generate
      if (DW < 2) begin : g_bad_width
         $error("xfer_parity: DW too small");
      end
      if (ODD) begin : g_odd
         assign rd_ok  = ^{rd_par, rd_data};
         assign wr_par = ~^wr_data;
      end else begin : g_even
         assign rd_ok  = ~^{rd_par, rd_data};
         assign wr_par = ^wr_data;
      end
   endgenerate
endmodule

// File: rtl/xfer_lane.sv
module xfer_lane #(
   parameter int CH    = 8,
   parameter int LANES = 4
) (
   input  logic [CH*LANES-1:0]      word,
   input  logic [$clog2(LANES)-1:0] sel,
   input  logic [CH-1:0]            ins,
   output logic [CH-1:0]            rd,
   output logic [CH*LANES-1:0]      merged
);
   localparam int LW = $clog2(LANES);

   generate
      if (LANES < 2 || (1 << LW) != LANES) begin : g_bad_lanes
         $error("xfer_lane: LANES must be a power of two >= 2");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign merged[g*CH +: CH] = (sel == LW'(g)) ? ins : word[g*CH +: CH];
      end
   endgenerate

   always_comb begin
      rd = '0;
      for (int i = 0; i < LANES; i++) begin
         if (sel == LW'(i)) rd = word[i*CH +: CH];
      end
   end
endmodule

// File: rtl/xfer_chan.sv
module xfer_chan
   import xfer_pkg::*;
#(
   parameter int AW   = 14,
   parameter int CW   = 8,
   parameter int DEVW = 4,
   parameter int OPW  = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [AW-1:0]   start_addr,
   output logic            busy,
   output logic            start_ignored,
   output logic            irq,
   output logic            err,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [31:0]     mem_wdata,
   output logic            mem_wpar,
   input  logic            mem_gnt,
   input  logic [31:0]     mem_rdata,
   input  logic            mem_rpar,
   output logic [DEVW-1:0] dev_sel,
   output logic [OPW-1:0]  dev_op,
   output logic            dev_out,
   output logic            dev_active,
   input  logic            dev_req,
   output logic            dev_ack,
   output logic [7:0]      dev_wdata,
   input  logic [7:0]      dev_rdata
);
   localparam int WW      = 32;
   localparam int CH      = 8;
   localparam int LANES   = WW / CH;
   localparam int LW      = $clog2(LANES);
   localparam int CAW     = AW + LW;
   localparam int OP_LSB  = FIELD_LSB;
   localparam int DEV_LSB = OP_LSB + OPW;

   generate
      if (DEV_LSB + DEVW > FLAG_BIT) begin : g_bad_cmd
         $error("xfer_chan: device and operation fields overflow the command word");
      end
      if (FIELD_LSB + CW > 24) begin : g_bad_cnt
         $error("xfer_chan: count field overflows the block-control word");
      end
      if (CAW > FIELD_LSB) begin : g_bad_addr
         $error("xfer_chan: character address wider than its field");
      end
   endgenerate

   xfer_state_t     st;
   logic [AW-1:0]   car, wbw;
   logic [WW-1:0]   hold, merged;
   logic [CAW-1:0]  caddr;
   logic [CW-1:0]   cnt;
   logic            chain;
   logic            pok;
   logic [CH-1:0]   lane_rd;

   xfer_parity #(.DW(WW), .ODD(1'b1)) u_par (
      .rd_data (mem_rdata),
      .rd_par  (mem_rpar),
      .rd_ok   (pok),
      .wr_data (hold),
      .wr_par  (mem_wpar)
   );

   xfer_lane #(.CH(CH), .LANES(LANES)) u_lane (
      .word   (hold),
      .sel    (caddr[LW-1:0]),
      .ins    (dev_rdata),
      .rd     (lane_rd),
      .merged (merged)
   );

   wire f_mark  = mem_rdata[MARK_BIT];
   wire f_flag  = mem_rdata[FLAG_BIT];
   wire at_last = (cnt == CW'(1));
   wire at_edge = (caddr[LW-1:0] == LW'(LANES-1));

   assign busy       = (st != S_IDLE);
   assign mem_req    = (st == S_FCMD) || (st == S_FBLK) || (st == S_FDATA) || (st == S_WBACK);
   assign mem_we     = (st == S_WBACK);
   assign mem_wdata  = hold;
   assign dev_active = (st == S_FBLK) || (st == S_FDATA) || (st == S_MOVE) || (st == S_WBACK);
   assign dev_ack    = (st == S_MOVE) && dev_req;
   assign dev_wdata  = lane_rd;

   always_comb begin
      unique case (st)
         S_FDATA: mem_addr = caddr[CAW-1:LW];
         S_WBACK: mem_addr = wbw;
         default: mem_addr = car;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st            <= S_IDLE;
         car           <= '0;
         wbw           <= '0;
         hold          <= '0;
         caddr         <= '0;
         cnt           <= '0;
         chain         <= 1'b0;
         dev_sel       <= '0;
         dev_op        <= '0;
         dev_out       <= 1'b0;
         irq           <= 1'b0;
         err           <= 1'b0;
         start_ignored <= 1'b0;
      end else begin
         irq           <= 1'b0;
         start_ignored <= start && (st != S_IDLE);
         unique case (st)
            S_IDLE: begin
               if (start) begin
                  car <= start_addr;
                  err <= 1'b0;
                  st  <= S_FCMD;
               end
            end
            S_FCMD: begin
               if (mem_gnt) begin
                  if (!pok || !f_mark) begin
                     err <= 1'b1;
                     irq <= 1'b1;
                     st  <= S_IDLE;
                  end else if (!f_flag) begin
                     st <= S_IDLE;
                  end else begin
                     dev_sel <= mem_rdata[DEV_LSB +: DEVW];
                     dev_op  <= mem_rdata[OP_LSB +: OPW];
                     dev_out <= mem_rdata[OP_LSB + OPW - 1];
                     car     <= car + AW'(1);
                     st      <= S_FBLK;
                  end
               end
            end
            S_FBLK: begin
               if (mem_gnt) begin
                  if (!pok || f_mark) begin
                     err <= 1'b1;
                     irq <= 1'b1;
                     st  <= S_IDLE;
                  end else begin
                     chain <= f_flag;
                     cnt   <= mem_rdata[FIELD_LSB +: CW];
                     caddr <= mem_rdata[CAW-1:0];
                     car   <= car + AW'(1);
                     if (mem_rdata[FIELD_LSB +: CW] != '0) begin
                        st <= S_FDATA;
                     end else if (!f_flag) begin
                        irq <= 1'b1;
                        st  <= S_IDLE;
                     end
                  end
               end
            end
            S_FDATA: begin
               if (mem_gnt) begin
                  if (!pok) begin
                     err <= 1'b1;
                     irq <= 1'b1;
                     st  <= S_IDLE;
                  end else begin
                     hold <= mem_rdata;
                     st   <= S_MOVE;
                  end
               end
            end
            S_MOVE: begin
               if (dev_req) begin
                  if (!dev_out) hold <= merged;
                  cnt   <= cnt - CW'(1);
                  caddr <= caddr + CAW'(1);
                  wbw   <= caddr[CAW-1:LW];
                  if (!dev_out && (at_last || at_edge)) begin
                     st <= S_WBACK;
                  end else if (at_last) begin
                     if (chain) st <= S_FBLK;
                     else begin
                        irq <= 1'b1;
                        st  <= S_IDLE;
                     end
                  end else if (at_edge) begin
                     st <= S_FDATA;
                  end
               end
            end
            S_WBACK: begin
               if (mem_gnt) begin
                  if (cnt != '0) st <= S_FDATA;
                  else if (chain) st <= S_FBLK;
                  else begin
                     irq <= 1'b1;
                     st  <= S_IDLE;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R11: acknowledge only answers a demand during an active data command
   p_ack_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> (dev_req && dev_active));

   // R10: an ungranted request keeps its address and direction
   p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R8: the completion interrupt lasts one cycle and the channel is idle then
   p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!busy ##1 !irq));

   // R9: an ignored start only happens while the channel was busy
   p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_ignored |-> $past(busy));

   // R6: no memory write during an output transfer
   p_no_write_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !dev_out);

   // R2: a new error always ends the transfer with the interrupt
   p_err_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (irq && !busy));
endmodule

// File: tb/xfer_chan_test.sv
module xfer_chan_test;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [13:0] start_addr = '0;
   logic        busy, start_ignored, irq, err;
   logic        mem_req, mem_we, mem_wpar;
   logic [13:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic        mem_gnt = 1'b0;
   logic        mem_rpar;
   logic [3:0]  dev_sel;
   logic [9:0]  dev_op;
   logic        dev_out, dev_active, dev_ack;
   logic        dev_req = 1'b0;
   logic [7:0]  dev_wdata;
   logic [7:0]  dev_rdata = '0;

   always #5 clk = ~clk;

   xfer_chan uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .busy(busy), .start_ignored(start_ignored), .irq(irq), .err(err),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_wpar(mem_wpar), .mem_gnt(mem_gnt),
      .mem_rdata(mem_rdata), .mem_rpar(mem_rpar),
      .dev_sel(dev_sel), .dev_op(dev_op), .dev_out(dev_out),
      .dev_active(dev_active), .dev_req(dev_req), .dev_ack(dev_ack),
      .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
   );

   logic [31:0] mem [256];
   logic        mpar [256];
   logic [31:0] exp_mem [256];
   logic [7:0]  exp_ch [64];
   logic [7:0]  got_ch [64];
   int n_exp, n_out, in_idx, in_pred;
   int stall = 0, gap = 1, wcnt = 0, dcnt = 0;
   int irq_cnt = 0, ign_cnt = 0;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   assign mem_rdata = mem[mem_addr[7:0]];
   assign mem_rpar  = mpar[mem_addr[7:0]];

   function automatic logic [7:0] inch(int k);
      return 8'(k * 13 + 7);
   endfunction

   function automatic logic [31:0] wval(int i);
      return {8'(i * 7 + 1), 8'(i ^ 8'h3C), 8'(i + 8'h40), 8'(i * 5)};
   endfunction

   function automatic logic [31:0] mk_cmd(bit moves, int dev, bit outdir, int op);
      return {1'b1, moves, 4'(dev), outdir, 9'(op), 16'h0};
   endfunction

   function automatic logic [31:0] mk_blk(bit ch, int n, int ca);
      return {1'b0, ch, 6'h0, 8'(n), 16'(ca)};
   endfunction

   task automatic put(int a, logic [31:0] d);
      mem[a]  = d;
      mpar[a] = ~^d;
   endtask

   task automatic chk(bit ok, string req, string what, longint act, longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // block descriptor plus expected-result bookkeeping
   task automatic add_blk(int at, bit ch, int n, int ca, bit outdir);
      put(at, mk_blk(ch, n, ca));
      for (int k = 0; k < n; k++) begin
         int c = ca + k;
         if (outdir) begin
            exp_ch[n_exp] = mem[c / 4][8 * (c % 4) +: 8];
            n_exp++;
         end else begin
            exp_mem[c / 4][8 * (c % 4) +: 8] = inch(in_pred);
            in_pred++;
         end
      end
   endtask

   task automatic prep();
      n_exp = 0;
      n_out = 0;
      in_pred = in_idx;
      for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
   endtask

   // memory grant, device demand and event monitor
   always @(negedge clk) begin
      mem_gnt = 1'b0;
      dev_req = 1'b0;
      if (mem_req) begin
         if (wcnt >= stall) begin
            mem_gnt = 1'b1;
            wcnt = 0;
         end else wcnt++;
      end
      dcnt++;
      if (dcnt >= gap) begin
         dev_req = 1'b1;
         dcnt = 0;
      end
      dev_rdata = inch(in_idx);
      if (irq) irq_cnt++;
      if (start_ignored) ign_cnt++;
      if (mem_req && mem_we && mem_gnt) begin
         mem[mem_addr[7:0]]  = mem_wdata;
         mpar[mem_addr[7:0]] = mem_wpar;
      end
      #1;
      if (dev_ack) begin
         if (dev_out) begin
            if (n_out < 64) got_ch[n_out] = dev_wdata;
            n_out++;
         end else in_idx++;
      end
   end

   task automatic run(int at, int poke, string req, output bit timed_out);
      int g = 0;
      timed_out = 1'b0;
      @(negedge clk);
      #2;
      start = 1'b1;
      start_addr = 14'(at);
      @(negedge clk);
      #2;
      start = 1'b0;
      chk(busy && mem_req && mem_addr == 14'(at), "R1", "busy and command fetch address",
          {busy, mem_req, 14'(mem_addr)}, {2'b11, 14'(at)});
      while (busy && g < 3000) begin
         @(negedge clk);
         #2;
         g++;
         if (g == poke) begin
            start = 1'b1;
            start_addr = 14'd200;
         end else start = 1'b0;
      end
      start = 1'b0;
      if (g >= 3000) begin
         timed_out = 1'b1;
         chk(1'b0, req, "transfer did not finish", g, 0);
      end
      @(negedge clk);
      #2;
   endtask

   task automatic cmp_chars(string req);
      bit ok = (n_out == n_exp);
      int bad = -1;
      for (int k = 0; k < n_exp && k < 64; k++)
         if (ok && got_ch[k] !== exp_ch[k]) begin
            ok = 1'b0;
            bad = k;
         end
      if (bad >= 0) chk(1'b0, req, "output character", got_ch[bad], exp_ch[bad]);
      else chk(ok, req, "output character count", n_out, n_exp);
   endtask

   task automatic cmp_mem(string req);
      bit ok = 1'b1;
      for (int i = 64; i < 128; i++)
         if (ok && (mem[i] !== exp_mem[i] || (^{mpar[i], mem[i]}) !== 1'b1)) begin
            ok = 1'b0;
            chk(1'b0, req, $sformatf("memory word %0d", i), mem[i], exp_mem[i]);
         end
      if (ok) chk(1'b1, req, "memory image", 0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      bit to;
      int i0, g0;
      in_idx = 0;
      for (int i = 0; i < 256; i++) put(i, wval(i));
      put(200, 32'h0000_0000);
      repeat (3) @(negedge clk);
      #2;
      chk(!busy && !irq && !err && !mem_req && !dev_active && !start_ignored, "R1",
          "reset state", {busy, irq, err, mem_req, dev_active}, 0);
      rst_n = 1'b1;

      // sweep grant stall against device demand spacing
      for (int s = 0; s < 3; s++) begin
         for (int gp = 1; gp < 4; gp++) begin
            stall = s;
            gap = gp;
            // chained output with an empty middle block
            prep();
            put(0, mk_cmd(1'b1, s * 3 + gp, 1'b1, 5 + gp));
            add_blk(1, 1'b1, 6, 4 * 64 + 1 + s, 1'b1);
            add_blk(2, 1'b1, 0, 0, 1'b1);
            add_blk(3, 1'b0, 5, 4 * 70 + 3, 1'b1);
            i0 = irq_cnt;
            run(0, 0, "R6", to);
            cmp_chars("R6");
            chk(irq_cnt == i0 + 1 && !err, "R8", "one interrupt, no error", irq_cnt - i0, 1);
            chk(dev_sel == 4'(s * 3 + gp) && dev_op == {1'b1, 9'(5 + gp)} && dev_out, "R11",
                "device select and operation", {dev_sel, dev_op}, {4'(s * 3 + gp), 1'b1, 9'(5 + gp)});
            cmp_mem("R6");
            // chained unaligned input
            prep();
            put(10, mk_cmd(1'b1, 9, 1'b0, gp));
            add_blk(11, 1'b1, 5, 4 * 80 + 2 + s, 1'b0);
            add_blk(12, 1'b0, 4 + gp, 4 * 84 + gp, 1'b0);
            i0 = irq_cnt;
            run(10, 0, "R7", to);
            cmp_mem("R7");
            chk(in_idx == in_pred && irq_cnt == i0 + 1 && !err && !dev_out, "R7",
                "input characters consumed", in_idx, in_pred);
         end
      end

      stall = 1;
      gap = 1;
      // bad command marker
      put(30, 32'h4000_0000);
      i0 = irq_cnt;
      run(30, 0, "R3", to);
      chk(err && irq_cnt == i0 + 1, "R3", "command marker error", {err, 8'(irq_cnt - i0)}, 9'h101);

      // bad parity on command
      put(31, mk_cmd(1'b1, 2, 1'b1, 1));
      mpar[31] = ~mpar[31];
      i0 = irq_cnt;
      run(31, 0, "R2", to);
      chk(err && irq_cnt == i0 + 1, "R2", "command parity error", {err, 8'(irq_cnt - i0)}, 9'h101);

      // non-data command
      prep();
      put(32, mk_cmd(1'b0, 3, 1'b1, 4));
      i0 = irq_cnt;
      run(32, 0, "R4", to);
      chk(!err && irq_cnt == i0 && n_out == 0, "R4", "non-data command quiet",
          {err, 8'(irq_cnt - i0), 8'(n_out)}, 0);

      // block word with command marker
      put(34, mk_cmd(1'b1, 1, 1'b1, 2));
      put(35, mk_cmd(1'b1, 1, 1'b1, 2));
      i0 = irq_cnt;
      run(34, 0, "R5", to);
      chk(err && irq_cnt == i0 + 1, "R5", "block marker error", {err, 8'(irq_cnt - i0)}, 9'h101);

      // bad parity on a data word
      put(37, mk_cmd(1'b1, 1, 1'b1, 2));
      put(38, mk_blk(1'b0, 3, 4 * 100));
      mpar[100] = ~mpar[100];
      i0 = irq_cnt;
      run(37, 0, "R2", to);
      chk(err && irq_cnt == i0 + 1, "R2", "data parity error", {err, 8'(irq_cnt - i0)}, 9'h101);
      mpar[100] = ~mpar[100];

      // start while busy is ignored
      gap = 3;
      prep();
      put(40, mk_cmd(1'b1, 7, 1'b1, 3));
      add_blk(41, 1'b0, 12, 4 * 90, 1'b1);
      i0 = irq_cnt;
      g0 = ign_cnt;
      run(40, 6, "R9", to);
      chk(ign_cnt == g0 + 1 && !err && irq_cnt == i0 + 1, "R9", "ignored start",
          ign_cnt - g0, 1);
      cmp_chars("R9");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule